// File: doc/BRIEF.md
# Sync-Gated Phase-Accumulating Oscillator

This block produces a running phase word for a carrier synthesizer. It keeps two 32-bit tuning words, a center term and an offset term. Each cycle that it runs, it adds their sum to a phase accumulator. A controller loads the tuning words one byte at a time over a narrow write port. A newly written word reaches the adder only when its least significant byte arrives. Until then the upper bytes wait in a staging register.

A reset from the controller stops the oscillator. The reset clears the phase accumulator and the start-up flags, and leaves both tuning words and their staging bytes unchanged. After a reset, two conditions must both be met before the phase moves again:
- A sync event must be seen. The sync event is either the external sync-detected strobe or a write to the least significant byte of the center word.
- A tuning word must be loaded, meaning the least significant byte of either word is written.

Until a sync event, the tuning terms feeding the adder are forced to zero. While the accumulator is held, the phase output reads zero and the valid strobe is low.

Top module: `sync_gated_nco`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, `phase_out` reads 0 and `phase_valid` reads 0 after that edge.
- R2: Reset does not alter the center or offset tuning words or their staged upper bytes. After reset, a sync pulse and a rewrite of only the offset low byte (same value) give a phase step equal to the tuning sum from before the reset.
- R3: After reset, `phase_out` stays 0 until the low byte (`wr_byte`=0) of either tuning word has been written, even if a sync has been seen.
- R4: After reset, the tuning terms contribute nothing until a sync event. A low-byte load without a sync leaves `phase_out` at 0 and `phase_valid` low.
- R5: A write to the center word (`wr_sel`=0) at `wr_byte`=0 counts as a sync event.
- R6: While running, `phase_out` advances by (center + offset) mod 2^32 on every clock edge. The first running cycle shows 0.
- R7: Writes to bytes 1..3 (`wr_byte`=1..3; byte k holds bits 8k+7:8k) only stage data. The phase step changes at the edge on which byte 0 of that word is written.
- R8: `phase_valid` is high exactly in cycles where both a sync event and a low-byte load have occurred since reset, and low otherwise. `phase_out` is 0 whenever `phase_valid` is low.
- R9: A one-cycle pulse on `sync_in` counts as a sync event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low controller reset |
| sync_in | input | 1 | Sync-detected strobe, one cycle |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 1 | Word select: 0 center, 1 offset |
| wr_byte | input | 2 | Byte index, 0 = least significant |
| wr_data | input | 8 | Byte value |
| phase_out | output | 32 | Accumulated phase |
| phase_valid | output | 1 | High while the accumulator runs |

## Verification
The assertions check every cycle that:
- the phase advances by exactly the current step while running;
- the step is zero before sync;
- the phase is zero while not loaded or not valid;
- the run state does not drop without reset;
- the tuning words hold unless a low byte is written.

Only the bench scenarios can show the following:
- that the tuning words survive a reset;
- that staged upper bytes combine correctly with a later low byte;
- that the sum wraps modulo 2^32.

The bench shows these by comparing the output against an arithmetic model across a sweep of tuning pairs and start-up orders.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic {
    SEL_CENTER = 1'b0,
    SEL_OFFSET = 1'b1
  } tune_sel_e;
endpackage

// File: rtl/nco_tune_reg.sv
module nco_tune_reg #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int NBYTES = WORD_W / BYTE_W,
  localparam int IDX_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              wr_hit,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_q,
  output logic              lo_load
);
  // staged upper bytes; not reset so contents survive controller reset
  logic [WORD_W-1:BYTE_W] stage_q = '0;
  logic [WORD_W-1:0]      word_r  = '0;

  assign lo_load = wr_hit && (wr_idx == '0);
  assign word_q  = word_r;

  always_ff @(posedge clk) begin
    for (int b = 1; b < NBYTES; b++) begin
      if (wr_hit && (wr_idx == IDX_W'(b)))
        stage_q[b*BYTE_W +: BYTE_W] <= wr_data;
    end
    if (lo_load)
      word_r <= {stage_q, wr_data};
  end
endmodule

// File: rtl/nco_start_gate.sv
module nco_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_evt,
  input  logic load_evt,
  output logic synced,
  output logic loaded
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synced <= 1'b0;
      loaded <= 1'b0;
    end else begin
      if (sync_evt) synced <= 1'b1;
      if (load_evt) loaded <= 1'b1;
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               synced,
  input  logic [PHASE_W-1:0] center,
  input  logic [PHASE_W-1:0] offset,
  output logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase_q
);
  function automatic logic [PHASE_W-1:0] gated_step(
    input logic gate, input logic [PHASE_W-1:0] a, input logic [PHASE_W-1:0] b);
    logic [PHASE_W-1:0] s;
    s = a + b;
    return gate ? s : '0;
  endfunction

  assign step = gated_step(synced, center, offset);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) phase_q <= '0;
    else                phase_q <= phase_q + step;
  end
endmodule

// File: rtl/sync_gated_nco.sv
module sync_gated_nco #(
  parameter int PHASE_W = 32,
  localparam int BYTE_W = nco_pkg::BYTE_W,
  localparam int IDX_W  = $clog2(PHASE_W / BYTE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_in,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [IDX_W-1:0]   wr_byte,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [PHASE_W-1:0] phase_out,
  output logic               phase_valid
);
  import nco_pkg::*;

  logic [1:0]         hit;
  logic [1:0]         lo_load;
  logic [PHASE_W-1:0] word [2];
  logic [PHASE_W-1:0] step;
  logic               sync_evt, load_evt, synced, loaded, run;

  assign hit[SEL_CENTER] = wr_en && (wr_sel == SEL_CENTER);
  assign hit[SEL_OFFSET] = wr_en && (wr_sel == SEL_OFFSET);

  for (genvar g = 0; g < 2; g++) begin : g_tune
    nco_tune_reg #(.WORD_W(PHASE_W), .BYTE_W(BYTE_W)) u_reg (
      .clk(clk), .wr_hit(hit[g]), .wr_idx(wr_byte), .wr_data(wr_data),
      .word_q(word[g]), .lo_load(lo_load[g]));
  end

  assign sync_evt = sync_in || lo_load[SEL_CENTER];
  assign load_evt = |lo_load;

  nco_start_gate u_gate (
    .clk(clk), .rst_n(rst_n), .sync_evt(sync_evt), .load_evt(load_evt),
    .synced(synced), .loaded(loaded));

  assign run = synced && loaded;

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(run), .synced(synced),
    .center(word[SEL_CENTER]), .offset(word[SEL_OFFSET]),
    .step(step), .phase_q(phase_out));

  assign phase_valid = run;
endmodule

// File: rtl/nco_checker.sv
module nco_checker #(
  parameter int PHASE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_in,
  input logic               cen_lo,
  input logic               any_lo,
  input logic               synced,
  input logic               loaded,
  input logic [PHASE_W-1:0] step,
  input logic [PHASE_W-1:0] center,
  input logic [PHASE_W-1:0] phase_out,
  input logic               phase_valid
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (phase_out == '0) && !phase_valid); // R1
  AST_TUNE_HOLDS: assert property (@(posedge clk)
    !cen_lo |=> $stable(center)); // R7
  AST_IDLE_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> phase_out == '0); // R3
  AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> step == '0); // R4
  AST_CENTER_SYNCS: assert property (@(posedge clk) disable iff (!rst_n)
    cen_lo |=> synced); // R5
  AST_PIN_SYNCS: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> synced); // R9
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_valid |=> phase_out == $past(phase_out) + $past(step)); // R6
  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_valid |-> phase_out == '0); // R8
  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_valid && rst_n) |=> phase_valid); // R8
  AST_LOAD_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    any_lo |=> loaded); // R3
endmodule

bind sync_gated_nco nco_checker #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
  .cen_lo(lo_load[nco_pkg::SEL_CENTER]), .any_lo(load_evt),
  .synced(synced), .loaded(loaded), .step(step),
  .center(word[nco_pkg::SEL_CENTER]),
  .phase_out(phase_out), .phase_valid(phase_valid));

// File: tb/sync_gated_nco_test.sv
module sync_gated_nco_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_in = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [1:0]  wr_byte = '0;
  logic [7:0]  wr_data = '0;
  logic [31:0] phase_out;
  logic        phase_valid;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  bit chk_on = 1'b0;

  // reference model state
  logic [31:0] m_c = '0, m_o = '0, m_cs = '0, m_os = '0, m_acc = '0;
  logic        m_sy = 1'b0, m_ld = 1'b0;
  logic        lc, lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_gated_nco uut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
    .phase_out(phase_out), .phase_valid(phase_valid));

  always @(posedge clk) begin
    lc = wr_en && !wr_sel && (wr_byte == 2'd0);
    lo = wr_en &&  wr_sel && (wr_byte == 2'd0);
    if (!rst_n) begin
      m_acc = '0; m_sy = 1'b0; m_ld = 1'b0;
    end else begin
      m_acc = (m_sy && m_ld) ? m_acc + (m_c + m_o) : 32'd0;
      if (sync_in || lc) m_sy = 1'b1;
      if (lc || lo)      m_ld = 1'b1;
    end
    if (wr_en && wr_byte != 2'd0) begin
      if (!wr_sel) m_cs[wr_byte*8 +: 8] = wr_data;
      else         m_os[wr_byte*8 +: 8] = wr_data;
    end
    if (lc) m_c = {m_cs[31:8], wr_data};
    if (lo) m_o = {m_os[31:8], wr_data};
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      check(phase_out == m_acc, {cur_tag, " phase"}, phase_out, m_acc);
      check(phase_valid == (m_sy && m_ld), {cur_tag, " valid"},
            32'(phase_valid), 32'(m_sy && m_ld));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_byte = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_word(input logic sel, input logic [31:0] w);
    for (int b = 3; b >= 0; b--) wr(sel, 2'(b), w[b*8 +: 8]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    cyc(2);
    check(phase_out == 0 && !phase_valid, "R1 reset clears", phase_out, 0);
    rst_n = 1'b1;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  function automatic logic [31:0] pick(input int i, input bit second);
    case (i)
      0: return second ? 32'h0000_0001 : 32'hFFFF_FFFF;
      1: return 32'h8000_0000;
      2: return second ? 32'h0000_0000 : 32'h0000_0001;
      3: return second ? 32'hFFFF_FF00 : 32'h0000_0100;
      default: return 32'h1357_9BDF * i + (second ? 32'h0F0F_0F0F * i : 32'h0000_0A0B);
    endcase
  endfunction

  logic [31:0] p0, p1;

  initial begin
    fork
      begin
        cyc(1); rst_n = 1'b0; cyc(2);
        check(phase_out == 0, "R1 phase at reset", phase_out, 0);
        check(!phase_valid, "R1 valid at reset", 32'(phase_valid), 0);
        chk_on = 1'b1;
        rst_n = 1'b1;

        cur_tag = "R3";
        pulse_sync();
        cyc(5);
        check(phase_out == 0 && !phase_valid, "R3 sync without load", phase_out, 0);

        cur_tag = "R9";
        wr_word(1'b1, 32'h0000_0010);
        cyc(1);
        check(phase_valid, "R9 sync pin then load runs", 32'(phase_valid), 1);
        cyc(3);
        check(phase_out == 32'h40, "R9 phase after pin sync", phase_out, 32'h40);

        cur_tag = "R4";
        do_reset();
        wr_word(1'b1, 32'h0000_0020);
        cyc(5);
        check(phase_out == 0 && !phase_valid, "R4 load without sync", phase_out, 0);

        cur_tag = "R5";
        wr_word(1'b0, 32'h0000_0003);
        check(phase_valid && phase_out == 0, "R5 first running cycle", phase_out, 0);
        cyc(2);
        check(phase_out == 32'h46, "R5 center low byte syncs", phase_out, 32'h46);

        cur_tag = "R7";
        wr(1'b0, 2'd3, 8'h10);
        p0 = phase_out; cyc(1); p1 = phase_out;
        check(p1 - p0 == 32'h23, "R7 upper byte staged only", p1 - p0, 32'h23);
        wr(1'b0, 2'd0, 8'h03);
        p0 = phase_out; cyc(1); p1 = phase_out;
        check(p1 - p0 == 32'h1000_0023, "R7 low byte commits", p1 - p0, 32'h1000_0023);

        cur_tag = "R2";
        do_reset();
        pulse_sync();
        wr(1'b1, 2'd0, 8'h20);
        p0 = phase_out; cyc(1); p1 = phase_out;
        check(p1 - p0 == 32'h1000_0023, "R2 words kept through reset", p1 - p0,
              32'h1000_0023);

        for (int i = 0; i < 12; i++) begin
          cur_tag = "R6";
          do_reset();
          wr_word(1'b1, pick(i, 1'b1));
          wr_word(1'b0, pick(i, 1'b0));
          cyc(20);
          check(phase_out == 32'(20 * (pick(i, 1'b0) + pick(i, 1'b1))),
                "R6 sweep accumulate", phase_out,
                32'(20 * (pick(i, 1'b0) + pick(i, 1'b1))));
          cur_tag = "R8";
          check(phase_valid, "R8 valid while running", 32'(phase_valid), 1);
        end

        cur_tag = "R1";
        @(negedge clk); rst_n = 1'b0;
        cyc(1);
        check(phase_out == 0 && !phase_valid, "R1 mid-run reset", phase_out, 0);
        rst_n = 1'b1;
        cyc(2);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule